// File: doc/BRIEF.md
# Charger Detection Mode Controller

This block supervises a USB charger detection front end. It watches three supply comparator flags (battery above its minimum, I/O supply present, VBUS valid) and the control pins from the application processor: shutdown, active-low output enable, the default-method strap and the bidirectional status/method pin. From these it decides whether the front end is powered down, in standby, or running a detection. It also chooses between hardware mode, used while the I/O supply is absent, and software mode. It then starts one of two external detection sequencers, current-sink or dedicated, and reports the result.

The two sequencers are outside this block. They receive a one-cycle start pulse or a one-cycle abort pulse, and they answer with `seq_done` and `seq_pass`. The analog comparators and pad drivers are modelled as digital flags. The status pin is split into a sensed input (`stat_in`), a drive enable (`stat_drv`) and a weak-pull level (`stat_lvl`). All timing is counted in clock ticks. The hardware retry interval is `RETRY_MS * TICKS_PER_MS` cycles.

The states are OFF, IDLE, LAUNCH, RUN, ABORT, RETRY and RESULT. Their transitions are:
- OFF to IDLE when the battery flag is set.
- IDLE to LAUNCH when VBUS is valid and either the I/O supply is absent or shutdown is low.
- LAUNCH to RUN.
- LAUNCH or RUN to ABORT on an interrupt condition.
- RUN to RESULT on a pass, or on a failure in software mode.
- RUN to RETRY on a failure in hardware mode.
- RETRY to LAUNCH when the timer expires.
- RETRY to IDLE on VBUS loss or when the I/O supply appears.
- ABORT to IDLE.
- RESULT to IDLE in software mode, on shutdown high or VBUS loss.
- Any state to OFF when the battery flag drops.

Top module: `chgdet_mode_ctrl`

## Requirements
- R1: When the synchronized battery flag is low, from the next cycle every output is low. This includes `det_en`, `det_out`, `stat_drv`, the start pulses and the abort pulse. Any held result is discarded.
- R2: The three supply flags pass through a two-flop synchronizer. From IDLE, a rise of `vbus_ok_a` produces a start pulse that is visible in the third cycle after the input changes, and not earlier.
- R3: With the I/O supply absent, the detection runs in hardware mode and the method comes from `dflt_method`. A value of 1 gives a pulse on `seq_start_cs` (current-sink). A value of 0 gives a pulse on `seq_start_dc` (dedicated).
- R4: With the I/O supply present, a detection starts only while VBUS is valid and `shutdown` is low. While `shutdown` is high the block stays in IDLE and issues no start.
- R5: In software mode, the method is the level of `stat_in` sampled in the cycle where `shutdown` goes from 1 to 0. A value of 1 selects current-sink and 0 selects dedicated. `dflt_method` has no effect.
- R6: `stat_drv` stays 0 until a sequencer reports done. After that it is 1 in RETRY and RESULT, and `stat_lvl` equals the pass result. It returns to 0 when those states are left.
- R7: `det_en` is 1 when the block is powered and either in hardware mode or with `oe_n` low. `det_out` is 1 only when `det_en` is 1 and a pass result is held.
- R8: A failed hardware detection with VBUS still valid enters RETRY. The next start pulse comes exactly RETRY_TICKS+1 cycles after the cycle in which `seq_done` was presented. This repeats for as long as the detection keeps failing.
- R9: RETRY returns to IDLE, without a new start, when VBUS becomes invalid or the I/O supply appears.
- R10: A hardware-mode pass result, with `det_out` high, is held through VBUS loss and through the arrival of the I/O supply. It is cleared only by reset or by loss of the battery flag.
- R11: During LAUNCH or RUN, any of these conditions produces a one-cycle `seq_abort` followed by IDLE: VBUS loss, `shutdown` high in software mode, or the I/O supply appearing in hardware mode. An abort condition takes priority over `seq_done` in the same cycle.
- R12: `seq_start_cs`, `seq_start_dc` and `seq_abort` are single-cycle pulses, and no two of them are ever high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| batt_ok_a | input | 1 | Battery-above-minimum comparator flag, asynchronous |
| vio_ok_a | input | 1 | I/O supply present flag, asynchronous |
| vbus_ok_a | input | 1 | VBUS valid flag, asynchronous |
| shutdown | input | 1 | Software standby request, active high |
| oe_n | input | 1 | Detect output enable in software mode, active low |
| dflt_method | input | 1 | Hardware-mode method strap: 1 current-sink, 0 dedicated |
| stat_in | input | 1 | Sensed level of the status/method pin |
| seq_done | input | 1 | Active sequencer finished its run |
| seq_pass | input | 1 | Result qualifier valid with seq_done |
| seq_start_cs | output | 1 | Start pulse for the current-sink sequencer |
| seq_start_dc | output | 1 | Start pulse for the dedicated sequencer |
| seq_abort | output | 1 | Abort pulse to the running sequencer |
| det_en | output | 1 | Detect output driver enabled |
| det_out | output | 1 | Detect output level |
| stat_drv | output | 1 | Status pin switched to output (weak pull active) |
| stat_lvl | output | 1 | Status pin pull direction: 1 up, 0 down |

## Verification
The delicate case is a sequencer reporting done in the same cycle that an interrupt condition reaches the state machine. Both are decided on one clock edge in RUN. The bench provokes this by dropping `vbus_ok_a` and then presenting `seq_done` with a pass exactly two cycles later, so that the synchronized VBUS fall and the done arrive together. The case is judged correct when an abort pulse appears next, the status pin stays an input, and the detect output stays low, showing that the pass was discarded.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_LAUNCH = 3'd2,
        ST_RUN    = 3'd3,
        ST_ABORT  = 3'd4,
        ST_RETRY  = 3'd5,
        ST_RESULT = 3'd6
    } chg_state_e;

    typedef enum logic {
        METH_DEDICATED = 1'b0,
        METH_CSINK     = 1'b1
    } chg_method_e;

endpackage

// File: rtl/chgdet_sync.sv
module chgdet_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            logic [WIDTH-1:0] r;
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= '0;
                    else        r <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) r <= '0;
                    else        r <= g_stage[gi-1].r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/chgdet_retry_timer.sv
module chgdet_retry_timer #(
    parameter int TICKS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    // The retry window never runs past its programmed length.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // The count only advances while the window is open.
    assert_cnt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/chgdet_method_latch.sv
module chgdet_method_latch
    import chgdet_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        shutdown,
    input  logic        stat_in,
    output chg_method_e method
);

    logic        sd_q;
    chg_method_e meth_q;
    logic        fall;

    assign fall = sd_q && !shutdown;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sd_q   <= 1'b0;
            meth_q <= METH_CSINK;
        end else begin
            sd_q <= shutdown;
            if (clr)       meth_q <= METH_CSINK;
            else if (fall) meth_q <= chg_method_e'(stat_in);
        end
    end

    // Bypass so that a launch in the falling-edge cycle sees the new method.
    assign method = fall ? chg_method_e'(stat_in) : meth_q;

    // Outside a falling edge the held method cannot change.
    assert_meth_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !clr) |=> $stable(meth_q));

endmodule

// File: rtl/chgdet_mode_ctrl.sv
module chgdet_mode_ctrl
    import chgdet_pkg::*;
#(
    parameter int TICKS_PER_MS = 50000,
    parameter int RETRY_MS     = 1000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic batt_ok_a,
    input  logic vio_ok_a,
    input  logic vbus_ok_a,
    input  logic shutdown,
    input  logic oe_n,
    input  logic dflt_method,
    input  logic stat_in,
    input  logic seq_done,
    input  logic seq_pass,
    output logic seq_start_cs,
    output logic seq_start_dc,
    output logic seq_abort,
    output logic det_en,
    output logic det_out,
    output logic stat_drv,
    output logic stat_lvl
);

    localparam int RETRY_TICKS = TICKS_PER_MS * RETRY_MS;
    localparam int NFLAG       = 3;

    logic [NFLAG-1:0] flags_s;
    logic             batt_s, vio_s, vbus_s;
    logic             retry_exp;
    logic             abort_req;
    logic             mode_hw;
    logic             hw_q;
    logic             pass_q;
    chg_method_e      sw_method;
    chg_method_e      meth_q;
    chg_state_e       st, nxt;

    chgdet_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({batt_ok_a, vio_ok_a, vbus_ok_a}),
        .q     (flags_s)
    );
    assign {batt_s, vio_s, vbus_s} = flags_s;

    chgdet_method_latch u_meth (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!batt_s),
        .shutdown (shutdown),
        .stat_in  (stat_in),
        .method   (sw_method)
    );

    chgdet_retry_timer #(.TICKS(RETRY_TICKS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st == ST_RETRY),
        .expire (retry_exp)
    );

    // Interrupt condition for a detection in flight.
    assign abort_req = !vbus_s || (hw_q ? vio_s : shutdown);

    always_comb begin
        nxt = st;
        if (!batt_s) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF:    nxt = ST_IDLE;
                ST_IDLE:   if (vbus_s && (!vio_s || !shutdown)) nxt = ST_LAUNCH;
                ST_LAUNCH: nxt = abort_req ? ST_ABORT : ST_RUN;
                ST_RUN: begin
                    if (abort_req)     nxt = ST_ABORT;
                    else if (seq_done) nxt = (seq_pass || !hw_q) ? ST_RESULT : ST_RETRY;
                end
                ST_ABORT:  nxt = ST_IDLE;
                ST_RETRY: begin
                    if (!vbus_s || vio_s) nxt = ST_IDLE;
                    else if (retry_exp)   nxt = ST_LAUNCH;
                end
                ST_RESULT: if (!hw_q && (shutdown || !vbus_s)) nxt = ST_IDLE;
                default:   nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            hw_q   <= 1'b0;
            meth_q <= METH_CSINK;
            pass_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == ST_IDLE && nxt == ST_LAUNCH) begin
                hw_q   <= !vio_s;
                meth_q <= !vio_s ? chg_method_e'(dflt_method) : sw_method;
            end else if (nxt == ST_OFF || nxt == ST_IDLE) begin
                hw_q <= 1'b0;
            end
            if (nxt != ST_RESULT)  pass_q <= 1'b0;
            else if (st == ST_RUN) pass_q <= seq_pass;
        end
    end

    always_comb begin
        mode_hw      = (st == ST_OFF || st == ST_IDLE) ? !vio_s : hw_q;
        seq_start_cs = (st == ST_LAUNCH) && (meth_q == METH_CSINK);
        seq_start_dc = (st == ST_LAUNCH) && (meth_q == METH_DEDICATED);
        seq_abort    = (st == ST_ABORT);
        det_en       = (st != ST_OFF) && (mode_hw || !oe_n);
        det_out      = det_en && pass_q;
        stat_drv     = (st == ST_RETRY) || (st == ST_RESULT);
        stat_lvl     = stat_drv && pass_q;
    end

    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !batt_s |=> (!det_en && !stat_drv && !seq_start_cs && !seq_start_dc && !seq_abort));

    assert_drv_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_drv) |-> $past(seq_done));

    assert_hw_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (det_out && hw_q && batt_s) |=> det_out);

    assert_abort_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && seq_done && !vbus_s && batt_s) |=> seq_abort);

    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({seq_start_cs, seq_start_dc, seq_abort}));

    assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start_cs || seq_start_dc) |=> !(seq_start_cs || seq_start_dc));

endmodule

// File: tb/sim_chgdet_mode_ctrl.sv
module sim_chgdet_mode_ctrl;

    localparam int TPM = 4;
    localparam int RMS = 5;
    localparam int RT  = TPM * RMS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic batt_ok_a = 1'b0, vio_ok_a = 1'b0, vbus_ok_a = 1'b0;
    logic shutdown = 1'b1, oe_n = 1'b1, dflt_method = 1'b1, stat_in = 1'b0;
    logic seq_done = 1'b0, seq_pass = 1'b0;
    logic seq_start_cs, seq_start_dc, seq_abort;
    logic det_en, det_out, stat_drv, stat_lvl;

    always #10 clk = ~clk;

    chgdet_mode_ctrl #(.TICKS_PER_MS(TPM), .RETRY_MS(RMS)) u0 (
        .clk(clk), .rst_n(rst_n), .batt_ok_a(batt_ok_a), .vio_ok_a(vio_ok_a),
        .vbus_ok_a(vbus_ok_a), .shutdown(shutdown), .oe_n(oe_n),
        .dflt_method(dflt_method), .stat_in(stat_in), .seq_done(seq_done),
        .seq_pass(seq_pass), .seq_start_cs(seq_start_cs), .seq_start_dc(seq_start_dc),
        .seq_abort(seq_abort), .det_en(det_en), .det_out(det_out),
        .stat_drv(stat_drv), .stat_lvl(stat_lvl)
    );

    typedef enum int {EV_CS, EV_DC, EV_AB} ev_e;
    ev_e   kq[$];
    string tq[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    fin = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(ev_e k, string tag);
        kq.push_back(k);
        tq.push_back(tag);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard whenever a pulse appears.
    always @(negedge clk) begin
        ev_e   got;
        ev_e   want;
        string tag;
        if (rst_n && !fin && (seq_start_cs || seq_start_dc || seq_abort)) begin
            got = seq_start_cs ? EV_CS : (seq_start_dc ? EV_DC : EV_AB);
            n_vec++;
            if ($countones({seq_start_cs, seq_start_dc, seq_abort}) > 1) begin
                n_bad++;
                $display("FAIL R12: pulses act=%0d exp=1",
                         $countones({seq_start_cs, seq_start_dc, seq_abort}));
            end else if (kq.size() == 0) begin
                n_bad++;
                $display("FAIL R12: unexpected act=%s exp=none", got.name());
            end else begin
                want = kq.pop_front();
                tag  = tq.pop_front();
                if (want != got) begin
                    n_bad++;
                    $display("FAIL %s: event act=%s exp=%s", tag, got.name(), want.name());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // Reset state: battery low, everything off
        chk("R1 reset det_en", det_en, 0);
        chk("R1 reset stat_drv", stat_drv, 0);

        // Power up, no I/O supply: hardware mode, detect always enabled
        batt_ok_a = 1'b1;
        tick(5);
        chk("R7 hw det_en", det_en, 1);
        chk("R7 hw det_out idle", det_out, 0);

        // R2/R3: VBUS rise launches current-sink on third cycle
        expect_ev(EV_CS, "R3");
        vbus_ok_a = 1'b1;
        tick(1); chk("R2 no early start 1", seq_start_cs, 0);
        tick(1); chk("R2 no early start 2", seq_start_cs, 0);
        tick(1); chk("R2 start cycle", seq_start_cs, 1);
        chk("R6 input during run", stat_drv, 0);

        // R8: failure, retry after RT+1 cycles
        expect_ev(EV_CS, "R8");
        tick(1); seq_done = 1'b1; seq_pass = 1'b0;
        tick(1); seq_done = 1'b0;
        chk("R6 drive after fail", stat_drv, 1);
        chk("R6 level after fail", stat_lvl, 0);
        tick(RT - 1); chk("R8 not before window", seq_start_cs, 0);
        tick(1);      chk("R8 retry start", seq_start_cs, 1);

        // R10: pass on retry is held
        tick(1); seq_done = 1'b1; seq_pass = 1'b1;
        tick(1); seq_done = 1'b0; seq_pass = 1'b0;
        chk("R10 det_out pass", det_out, 1);
        chk("R6 level pass", stat_lvl, 1);
        vbus_ok_a = 1'b0;
        tick(5); chk("R10 held over vbus loss", det_out, 1);
        vio_ok_a = 1'b1;
        tick(5); chk("R10 held over vio", det_out, 1);

        // R1: battery loss clears everything
        batt_ok_a = 1'b0;
        tick(3);
        chk("R1 det_out off", det_out, 0);
        chk("R1 det_en off", det_en, 0);
        chk("R1 stat_drv off", stat_drv, 0);
        batt_ok_a = 1'b1;
        tick(4);
        chk("R1 result discarded", det_out, 0);

        // R5: software, method latched low -> dedicated, strap ignored
        stat_in = 1'b0; dflt_method = 1'b1;
        tick(1); shutdown = 1'b0;
        tick(2);
        expect_ev(EV_DC, "R5");
        vbus_ok_a = 1'b1;
        tick(3); chk("R5 dedicated start", seq_start_dc, 1);
        tick(1); chk("R7 sw disabled oe_n=1", det_en, 0);
        seq_done = 1'b1; seq_pass = 1'b1;
        tick(1); seq_done = 1'b0; seq_pass = 1'b0;
        chk("R6 sw drive", stat_drv, 1);
        chk("R6 sw level", stat_lvl, 1);
        chk("R7 sw gated", det_out, 0);
        oe_n = 1'b0;
        tick(1); chk("R7 sw enabled", det_out, 1);

        // R4: shutdown high -> standby, no launch
        shutdown = 1'b1;
        tick(2);
        chk("R4 standby stat_drv", stat_drv, 0);
        chk("R4 standby det_out", det_out, 0);
        tick(8);
        chk("R4 no launch in standby", kq.size(), 0);

        // R5/R11: latch current-sink, then abort via shutdown
        stat_in = 1'b1;
        expect_ev(EV_CS, "R5");
        shutdown = 1'b0;
        tick(1); chk("R5 current-sink start", seq_start_cs, 1);
        expect_ev(EV_AB, "R11");
        tick(1); shutdown = 1'b1;
        tick(1); chk("R11 shutdown abort", seq_abort, 1);
        tick(2);

        // R11: abort and done in the same cycle, abort wins
        expect_ev(EV_CS, "R11");
        shutdown = 1'b0;
        tick(1); chk("R11 start", seq_start_cs, 1);
        expect_ev(EV_AB, "R11");
        tick(1); vbus_ok_a = 1'b0;
        tick(2); seq_done = 1'b1; seq_pass = 1'b1;
        tick(1); chk("R11 abort beats done", seq_abort, 1);
        seq_done = 1'b0; seq_pass = 1'b0;
        tick(2);
        chk("R11 no result drive", stat_drv, 0);
        chk("R11 no detect", det_out, 0);

        // R3/R9: hardware dedicated, retry stopped by I/O supply
        vio_ok_a = 1'b0; shutdown = 1'b1; dflt_method = 1'b0;
        tick(4);
        expect_ev(EV_DC, "R3");
        vbus_ok_a = 1'b1;
        tick(3); chk("R3 dedicated start", seq_start_dc, 1);
        tick(1); seq_done = 1'b1; seq_pass = 1'b0;
        tick(1); seq_done = 1'b0;
        tick(3);
        chk("R6 retry drive", stat_drv, 1);
        chk("R7 hw det_en retry", det_en, 1);
        chk("R7 hw det_out fail", det_out, 0);
        vio_ok_a = 1'b1;
        tick(RT + 5);
        chk("R9 vio stops retry", kq.size(), 0);
        chk("R9 idle after vio", stat_drv, 0);

        // R9: retry stopped by VBUS loss
        expect_ev(EV_DC, "R3");
        vio_ok_a = 1'b0;
        tick(3); chk("R3 dedicated relaunch", seq_start_dc, 1);
        tick(1); seq_done = 1'b1; seq_pass = 1'b0;
        tick(1); seq_done = 1'b0;
        tick(3);
        vbus_ok_a = 1'b0;
        tick(RT + 5);
        chk("R9 vbus stops retry", kq.size(), 0);
        chk("R9 idle after vbus", stat_drv, 0);

        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule